// File: doc/BRIEF.md
# Split IRQ/FIQ Interrupt Controller

This block gathers fourteen interrupt sources of a small 32-bit microcontroller and turns them into two request lines for the CPU: a normal interrupt (`irq_o`) and a fast interrupt (`fiq_o`). Sources belong to one of two classes, and a fixed level mask decides the class. A level-class source is copied into a status register, which follows the source: the bit is set when the source rises and cleared when it falls. A latch-class source is captured into a hold register on its rising edge. The bit stays set until software acknowledges it or the source falls.

Only the hold register can raise a request. Each held bit is gated by its enable bit and then routed through one of two fixed masks. One mask feeds `irq_o` and the other feeds `fiq_o`. With the default masks, the communication source (bit 6) and timer 2 (bit 13) are the only fast interrupts. Software uses a plain 32-bit register port with byte offsets. It sets enable bits at one offset and clears them at another, and it acknowledges held and status bits with a write-one-to-clear offset. Reads are combinational.

Top module: `irq_split_ctrl`

## Requirements
- R1: After reset, the hold, status and enable registers read zero, and both `irq_o` and `fiq_o` are low.
- R2: On a rising source edge, a bit inside the level mask (default 0x021F: buttons 0-4 and RTC bit 9) is set in status (offset 0x04). Any other bit is set in hold (offset 0x00). A level-class bit never appears in hold.
- R3: One cycle after a write or source change, `irq_o` is high exactly when hold & enable & 0x1FBF is nonzero, and `fiq_o` is high exactly when hold & enable & 0x2040 is nonzero.
- R4: On a falling source edge, that bit is cleared in both hold and status.
- R5: A write to offset 0x08 ORs the data into enable, and reading 0x08 returns enable. A write to offset 0x0C clears the enable bits that are 1 in the data.
- R6: A write to offset 0x10 clears the data's 1 bits from both hold and status.
- R7: When an acknowledge and a rising edge of the same bit occur in the same cycle, the new edge wins and the bit ends up set.
- R8: Reads of offsets 0x0C and 0x10 return zero. Writes to offsets 0x00 and 0x04 leave hold and status unchanged.
- R9: Any unmapped offset reads zero, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 14 | Interrupt source levels |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
Single rising edges on a latch-class timer source, a level-class button and an RTC source show whether the class split steers each bit to hold or to status. Edges on the communication source and on timer 2 show whether the FIQ/IRQ routing is correct. Falling edges with both registers populated, together with set/clear enable sequences, separate a source drop from a mask action: after a mask the held bit survives but the request drops. An acknowledge issued in the same cycle as a fresh edge exposes the ordering of clear and set. Writes to the read-only offsets and to an unmapped offset, each followed by read-back, confirm that these writes have no effect.

// File: rtl/irq_split_ctrl.sv
module irq_split_ctrl #(
  parameter int          NSRC       = 14,
  parameter int          ADDR_W     = 8,
  parameter int          DATA_W     = 32,
  parameter logic [13:0] LEVEL_MASK = 14'h021F,
  parameter logic [13:0] IRQ_MASK   = 14'h1FBF,
  parameter logic [13:0] FIQ_MASK   = 14'h2040
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              fiq_o
);
  localparam logic [ADDR_W-1:0] OFF_HOLD = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] OFF_STAT = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] OFF_ENA  = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] OFF_DIS  = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] OFF_ACK  = ADDR_W'(8'h10);
  localparam logic [NSRC-1:0]   LVL = NSRC'(LEVEL_MASK);
  localparam logic [NSRC-1:0]   IRM = NSRC'(IRQ_MASK);
  localparam logic [NSRC-1:0]   FQM = NSRC'(FIQ_MASK);

  logic [NSRC-1:0] src_q, hold_q, status_q, en_q;
  logic [NSRC-1:0] hold_n, status_n, en_n;
  logic [NSRC-1:0] rise, fall, wbits, ack, set_en, clr_en;
  logic            irq_q, fiq_q;

  assign rise   = src_i & ~src_q;
  assign fall   = ~src_i & src_q;
  assign wbits  = wdata_i[NSRC-1:0];
  assign ack    = (we_i && addr_i == OFF_ACK) ? wbits : '0;
  assign set_en = (we_i && addr_i == OFF_ENA) ? wbits : '0;
  assign clr_en = (we_i && addr_i == OFF_DIS) ? wbits : '0;

  assign hold_n   = (hold_q   & ~fall & ~ack) | (rise & ~LVL);
  assign status_n = (status_q & ~fall & ~ack) | (rise &  LVL);
  assign en_n     = (en_q | set_en) & ~clr_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q    <= '0;
      hold_q   <= '0;
      status_q <= '0;
      en_q     <= '0;
      irq_q    <= 1'b0;
      fiq_q    <= 1'b0;
    end else begin
      src_q    <= src_i;
      hold_q   <= hold_n;
      status_q <= status_n;
      en_q     <= en_n;
      irq_q    <= |(hold_n & en_n & IRM);
      fiq_q    <= |(hold_n & en_n & FQM);
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFF_HOLD: rdata_o = DATA_W'(hold_q);
      OFF_STAT: rdata_o = DATA_W'(status_q);
      OFF_ENA:  rdata_o = DATA_W'(en_q);
      default:  rdata_o = '0;
    endcase
  end

  assign irq_o = irq_q;
  assign fiq_o = fiq_q;

  AST_LEVEL_NOT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ((hold_q & LVL) == '0)); // R2
  AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (irq_o == |(hold_q & en_q & IRM))); // R3
  AST_FIQ_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (fiq_o == |(hold_q & en_q & FQM))); // R3
  AST_LOW_SRC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (((hold_q | status_q) & ~src_q) == '0)); // R4
  AST_ENABLE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && addr_i == OFF_ENA) |=> ((en_q & $past(wbits)) == $past(wbits))); // R5
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && addr_i == OFF_ACK && rise == '0) |=>
      (((hold_q | status_q) & $past(wbits)) == '0)); // R6
  AST_RO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && (addr_i == OFF_HOLD || addr_i == OFF_STAT) && src_i == src_q) |=>
      ($stable(hold_q) && $stable(status_q))); // R8
endmodule

// File: tb/irq_split_ctrl_test.sv
module irq_split_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] src = '0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, fiq;

  int checks = 0, errors = 0;
  logic        obs_req = 1'b0;
  logic        obs_out = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  bit          done = 1'b0;

  always #2 clk = ~clk;

  irq_split_ctrl uut (
    .clk(clk), .rst_n(rst_n), .src_i(src), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .fiq_o(fiq)
  );

  always @(negedge clk) begin
    if (obs_req && exp_q.size() > 0) begin
      logic [31:0] e, a;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = obs_out ? {30'd0, irq, fiq} : rdata;
      checks++;
      if (a !== e) begin
        errors++;
        $display("FAIL %s: actual %h expected %h", t, a, e);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); we <= 1'b1; addr <= a; wdata <= d;
    @(posedge clk); we <= 1'b0;
  endtask

  task automatic drive_src(input logic [13:0] v);
    @(posedge clk); src <= v;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    @(posedge clk); addr <= a; obs_out <= 1'b0; obs_req <= 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(posedge clk); obs_req <= 1'b0;
  endtask

  task automatic chk_out(input logic i, input logic f, input string t);
    @(posedge clk); obs_out <= 1'b1; obs_req <= 1'b1;
    exp_q.push_back({30'd0, i, f}); tag_q.push_back(t);
    @(posedge clk); obs_req <= 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n <= 1'b1;
    rd(8'h00, 0, "R1 hold");
    rd(8'h04, 0, "R1 status");
    rd(8'h08, 0, "R1 enable");
    chk_out(0, 0, "R1 outputs");

    wr(8'h08, 32'h0000_3FFF);
    rd(8'h08, 32'h3FFF, "R5 enable set");
    rd(8'h0C, 0, "R8 mask read");
    rd(8'h10, 0, "R8 ack read");

    drive_src(14'h0080);
    chk_out(1, 0, "R3 timer0 irq");
    rd(8'h00, 32'h80, "R2 timer0 held");
    rd(8'h04, 0, "R2 timer0 not in status");

    wr(8'h10, 32'h80);
    rd(8'h00, 0, "R6 ack hold");
    chk_out(0, 0, "R6 irq dropped");

    drive_src(14'h0081);
    rd(8'h04, 32'h01, "R2 button status");
    rd(8'h00, 0, "R2 button not held");
    chk_out(0, 0, "R3 level no irq");

    drive_src(14'h2081);
    chk_out(0, 1, "R3 timer2 fiq");
    drive_src(14'h20C1);
    rd(8'h00, 32'h2040, "R2 com and timer2 held");

    wr(8'h0C, 32'h2000);
    rd(8'h08, 32'h1FFF, "R5 mask clears");
    chk_out(0, 1, "R3 com still fiq");
    wr(8'h0C, 32'h0040);
    chk_out(0, 0, "R3 fiq masked");
    rd(8'h00, 32'h2040, "R5 mask keeps hold");

    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, 32'h2040, "R8 hold write ignored");
    wr(8'h04, 32'h0);
    rd(8'h04, 32'h01, "R8 status write ignored");

    drive_src(14'h0081);
    rd(8'h00, 0, "R4 fall clears hold");
    drive_src(14'h0080);
    rd(8'h04, 0, "R4 fall clears status");
    drive_src(14'h0280);
    rd(8'h04, 32'h200, "R2 rtc status");
    wr(8'h10, 32'h200);
    rd(8'h04, 0, "R6 ack status");

    wr(8'h14, 32'hFFFF_FFFF);
    rd(8'h14, 0, "R9 unmapped read");
    rd(8'h08, 32'h1FBF, "R9 unmapped write ignored");

    @(posedge clk); src <= 14'h0380; we <= 1'b1; addr <= 8'h10; wdata <= 32'h100;
    @(posedge clk); we <= 1'b0;
    rd(8'h00, 32'h100, "R7 edge beats ack");
    chk_out(1, 0, "R7 irq set");

    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule